// File: doc/BRIEF.md
# Programmable Memory Control-Line Sequencer

This block turns a stream of memory-controller microcode words into six general-purpose memory control outputs. The microcode machine presents one word per bus cycle. The block runs on a clock that ticks once per quarter of that bus cycle. A 2-bit quarter indicator tells it where it stands in the cycle. Each control line moves only at two points in a bus cycle: on entry to quarter 2 (edge one) and on entry to quarter 4 (edge two). Lines 1 to 4 take one plain bit per edge. Line 0 takes a 2-bit code per edge, which can drive low, drive high, hold, or (when both codes request it) follow an address bit picked by a configuration field.

Line 5 has two extra features. During the first cycle of a memory access it ignores the word and is driven from a per-bank option value on entry to quarter 4, so that it asserts together with the transfer-start strobe. When the second machine runs the access, a per-bank select bit chooses which of two line-5 outputs is driven, and the other output keeps its value. Whenever no pattern is running, every output goes to its negated level, which is high.

Top module: `ctl_line_seq`

## Requirements
- R1: After reset, and on every clock edge where `run_i` is low, all five `line_o` bits and both `l5_o` bits are registered high.
- R2: On an edge where `run_i` is high and `quarter_i` is 0 (quarter 1, leaving for quarter 2), `line_o[k]` for k = 1..4 takes `word_i[k-1]` (edge-one bits in `word_i[4:0]`, bit 0 for line 1).
- R3: On an edge where `run_i` is high and `quarter_i` is 2 (quarter 3, leaving for quarter 4), `line_o[k]` for k = 1..4 takes `word_i[k+4]` (edge-two bits in `word_i[9:5]`, bit 5 for line 1).
- R4: On an edge where `run_i` is high and `quarter_i` is 1 or 3, no output changes.
- R5: Line 0 (`line_o[0]`) uses code `word_i[11:10]` at edge one and code `word_i[13:12]` at edge two: 00 drives low, 01 drives high, 10 holds the previous value.
- R6: When both line-0 codes are 11, line 0 takes `addr_i[sel_i]` at each edge. The address used is live on the edge with `first_i` high and `quarter_i` 0, and that value is latched for the rest of the access.
- R7: A code of 11 while the other line-0 code is not 11 holds line 0.
- R8: In a first cycle (`first_i` high) with `periodic_i` low, line 5 holds at edge one and takes `early_i` at edge two, ignoring word bits.
- R9: In a first cycle with `periodic_i` high, line 5 takes its word bits like any later cycle.
- R10: Outside the first cycle, line 5 takes `word_i[4]` at edge one and `word_i[9]` at edge two.
- R11: The active line-5 output is `l5_o[bank_sel_i]` when `mach_b_i` is high and `l5_o[0]` otherwise. While `run_i` is high, the inactive output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | A microcode pattern is running |
| quarter_i | input | 2 | Current quarter of the bus cycle, 0..3 for quarters 1..4 |
| first_i | input | 1 | Current bus cycle is the first of the access |
| periodic_i | input | 1 | Pattern was started by the periodic timer |
| mach_b_i | input | 1 | The second machine runs this access |
| bank_sel_i | input | 1 | Per-bank line-5 output select |
| early_i | input | 1 | Per-bank first-cycle line-5 value |
| word_i | input | 14 | Current microcode word |
| addr_i | input | ADDR_W | Address bus |
| sel_i | input | SEL_W | Address-bit select for line 0 |
| line_o | output | 5 | Control lines 0..4 |
| l5_o | output | 2 | Line-5 output pair |

## Verification
The bench uses the default ADDR_W of 8, so SEL_W is 3. Every select value then points at a real address input, and random selects cover all eight. The address bus is re-randomised after the first quarter of each access. A design that read the live bus instead of the latched value would therefore diverge on follow-mode edges. Random requests mix timer and memory accesses and both machines with both select values, so the early line-5 path and the hold on the inactive output are exercised in each combination.

// File: rtl/ctl_line_pkg.sv
package ctl_line_pkg;

    localparam int WORD_W = 14;
    localparam int GP_N   = 4;

    typedef struct packed {
        logic [1:0]      l0_e2;
        logic [1:0]      l0_e1;
        logic [GP_N:0]   e2;
        logic [GP_N:0]   e1;
    } mc_word_t;

    typedef enum logic [1:0] {
        L0_LOW  = 2'b00,
        L0_HIGH = 2'b01,
        L0_HOLD = 2'b10,
        L0_ADDR = 2'b11
    } l0_code_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_ONE  = 2'd1,
        EDGE_TWO  = 2'd2
    } edge_e;

    function automatic edge_e edge_of(input logic [1:0] q);
        case (q)
            2'd0:    return EDGE_ONE;
            2'd2:    return EDGE_TWO;
            default: return EDGE_NONE;
        endcase
    endfunction

    function automatic logic l0_next(input logic [1:0] code, input logic follow,
                                     input logic abit, input logic cur);
        if (follow) return abit;
        case (l0_code_e'(code))
            L0_LOW:  return 1'b0;
            L0_HIGH: return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/ctl_line_addr.sv
module ctl_line_addr #(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  sel,
    output logic              abit
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (capture) addr_q <= addr;
    end

    assign abit = capture ? addr[sel] : addr_q[sel];
endmodule

// File: rtl/ctl_line_l0.sv
module ctl_line_l0
    import ctl_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  edge_e      edg,
    input  logic [1:0] code_e1,
    input  logic [1:0] code_e2,
    input  logic       abit,
    output logic       line
);
    logic follow;
    logic [1:0] code;

    assign follow = (code_e1 == L0_ADDR) && (code_e2 == L0_ADDR);
    assign code   = (edg == EDGE_TWO) ? code_e2 : code_e1;

    always_ff @(posedge clk) begin
        if (rst || !run)             line <= 1'b1;
        else if (edg != EDGE_NONE)   line <= l0_next(code, follow, abit, line);
    end

    AST_L0_FOLLOW: assert property (@(posedge clk) disable iff (rst) (run && edg != EDGE_NONE && follow) |=> line == $past(abit)) else $error("l0 follow"); // R6
    AST_L0_LONE_HOLD: assert property (@(posedge clk) disable iff (rst) (run && edg != EDGE_NONE && !follow && code == L0_ADDR) |=> $stable(line)) else $error("l0 lone"); // R7
endmodule

// File: rtl/ctl_line_gp.sv
module ctl_line_gp
    import ctl_line_pkg::*;
#(
    parameter int N = GP_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  edge_e        edg,
    input  logic [N-1:0] e1,
    input  logic [N-1:0] e2,
    output logic [N-1:0] lines
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || !run)          lines[i] <= 1'b1;
            else if (edg == EDGE_ONE) lines[i] <= e1[i];
            else if (edg == EDGE_TWO) lines[i] <= e2[i];
        end
    end

    AST_GP_EDGE_ONE: assert property (@(posedge clk) disable iff (rst) (run && edg == EDGE_ONE) |=> lines == $past(e1)) else $error("gp e1"); // R2
    AST_GP_EDGE_TWO: assert property (@(posedge clk) disable iff (rst) (run && edg == EDGE_TWO) |=> lines == $past(e2)) else $error("gp e2"); // R3
endmodule

// File: rtl/ctl_line_l5.sv
module ctl_line_l5
    import ctl_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  edge_e      edg,
    input  logic       first,
    input  logic       periodic,
    input  logic       early,
    input  logic       mach_b,
    input  logic       bank_sel,
    input  logic       b1,
    input  logic       b2,
    output logic [1:0] l5
);
    logic       early_mode;
    logic       upd;
    logic       val;
    logic [1:0] act_mask;

    assign early_mode = first && !periodic;
    assign act_mask   = (mach_b && bank_sel) ? 2'b10 : 2'b01;

    always_comb begin
        upd = 1'b0;
        val = 1'b1;
        case (edg)
            EDGE_ONE: begin upd = !early_mode; val = b1; end
            EDGE_TWO: begin upd = 1'b1; val = early_mode ? early : b2; end
            default:  ;
        endcase
    end

    for (genvar i = 0; i < 2; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst || !run)             l5[i] <= 1'b1;
            else if (upd && act_mask[i]) l5[i] <= val;
        end
    end

    AST_L5_EARLY: assert property (@(posedge clk) disable iff (rst) (run && early_mode && edg == EDGE_TWO) |=> (l5 & $past(act_mask)) == ($past(early) ? $past(act_mask) : 2'b00)) else $error("l5 early"); // R8
    AST_L5_EARLY_E1_HOLD: assert property (@(posedge clk) disable iff (rst) (run && early_mode && edg == EDGE_ONE) |=> $stable(l5)) else $error("l5 e1 hold"); // R8
    AST_L5_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst) run |=> (l5 & ~$past(act_mask)) == ($past(l5) & ~$past(act_mask))) else $error("l5 inactive"); // R11
endmodule

// File: rtl/ctl_line_seq.sv
module ctl_line_seq
    import ctl_line_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [1:0]        quarter_i,
    input  logic              first_i,
    input  logic              periodic_i,
    input  logic              mach_b_i,
    input  logic              bank_sel_i,
    input  logic              early_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [GP_N:0]     line_o,
    output logic [1:0]        l5_o
);
    mc_word_t        w;
    edge_e           edg;
    logic            capture;
    logic            abit;
    logic            l0;
    logic [GP_N-1:0] gp;

    assign w       = mc_word_t'(word_i);
    assign edg     = edge_of(quarter_i);
    assign capture = run_i && first_i && (quarter_i == 2'd0);

    ctl_line_addr #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_addr (
        .clk(clk), .rst(rst), .capture(capture), .addr(addr_i), .sel(sel_i), .abit(abit)
    );

    ctl_line_l0 u_l0 (
        .clk(clk), .rst(rst), .run(run_i), .edg(edg),
        .code_e1(w.l0_e1), .code_e2(w.l0_e2), .abit(abit), .line(l0)
    );

    ctl_line_gp #(.N(GP_N)) u_gp (
        .clk(clk), .rst(rst), .run(run_i), .edg(edg),
        .e1(w.e1[GP_N-1:0]), .e2(w.e2[GP_N-1:0]), .lines(gp)
    );

    ctl_line_l5 u_l5 (
        .clk(clk), .rst(rst), .run(run_i), .edg(edg),
        .first(first_i), .periodic(periodic_i), .early(early_i),
        .mach_b(mach_b_i), .bank_sel(bank_sel_i),
        .b1(w.e1[GP_N]), .b2(w.e2[GP_N]), .l5(l5_o)
    );

    assign line_o = {gp, l0};

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) $past(!run_i) |-> (&line_o && &l5_o)) else $error("idle"); // R1
    AST_QUIET_QUARTER: assert property (@(posedge clk) disable iff (rst) (run_i && quarter_i[0]) |=> ($stable(line_o) && $stable(l5_o))) else $error("quiet"); // R4
endmodule

// File: tb/ctl_line_seq_tb.sv
module ctl_line_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic [1:0]  quarter_i = 2'd0;
    logic        first_i = 1'b0;
    logic        periodic_i = 1'b0;
    logic        mach_b_i = 1'b0;
    logic        bank_sel_i = 1'b0;
    logic        early_i = 1'b0;
    logic [13:0] word_i = '0;
    logic [7:0]  addr_i = '0;
    logic [2:0]  sel_i = '0;
    logic [4:0]  line_o;
    logic [1:0]  l5_o;

    int tests = 0;
    int fails = 0;

    logic [3:0] e_gp;
    logic       e_l0;
    logic [1:0] e_l5;
    logic [7:0] e_aq;

    ctl_line_seq #(.ADDR_W(8), .SEL_W(3)) u_dut (
        .clk(clk), .rst(rst), .run_i(run_i), .quarter_i(quarter_i), .first_i(first_i),
        .periodic_i(periodic_i), .mach_b_i(mach_b_i), .bank_sel_i(bank_sel_i),
        .early_i(early_i), .word_i(word_i), .addr_i(addr_i), .sel_i(sel_i),
        .line_o(line_o), .l5_o(l5_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic l0_code(input logic [1:0] c, input logic fol,
                                     input logic ab, input logic cur);
        if (fol) return ab;
        if (c == 2'b00) return 1'b0;
        if (c == 2'b01) return 1'b1;
        return cur;
    endfunction

    task automatic all_high_expect();
        e_gp = 4'hF; e_l0 = 1'b1; e_l5 = 2'b11;
    endtask

    task automatic step(input logic act, input logic fc, input logic per, input logic mb,
                        input logic bs, input logic ea, input logic [1:0] q,
                        input logic [13:0] w, input logic [7:0] a, input logic [2:0] s);
        string t_gp, t_l0, t_l5, t_in;
        logic ab, fol, v5, upd5;
        int ai;
        run_i = act; first_i = fc; periodic_i = per; mach_b_i = mb; bank_sel_i = bs;
        early_i = ea; quarter_i = q; word_i = w; addr_i = a; sel_i = s;
        ai = (mb && bs) ? 1 : 0;
        t_in = "R11";
        if (!act) begin
            all_high_expect();
            t_gp = "R1"; t_l0 = "R1"; t_l5 = "R1"; t_in = "R1";
        end else begin
            ab  = (fc && q == 2'd0) ? a[s] : e_aq[s];
            if (fc && q == 2'd0) e_aq = a;
            fol = (w[11:10] == 2'b11) && (w[13:12] == 2'b11);
            if (q == 2'd0 || q == 2'd2) begin
                logic [1:0] c;
                c = (q == 2'd0) ? w[11:10] : w[13:12];
                t_gp = (q == 2'd0) ? "R2" : "R3";
                e_gp = (q == 2'd0) ? w[3:0] : w[8:5];
                t_l0 = fol ? "R6" : (c == 2'b11 ? "R7" : "R5");
                e_l0 = l0_code(c, fol, ab, e_l0);
                if (fc && !per) begin
                    t_l5 = "R8"; upd5 = (q == 2'd2); v5 = ea;
                end else begin
                    t_l5 = fc ? "R9" : "R10"; upd5 = 1'b1;
                    v5 = (q == 2'd0) ? w[4] : w[9];
                end
                if (upd5) e_l5[ai] = v5;
            end else begin
                t_gp = "R4"; t_l0 = "R4"; t_l5 = "R4";
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(t_gp, line_o[4:1], e_gp);
        chk(t_l0, {3'b0, line_o[0]}, {3'b0, e_l0});
        chk(t_l5, {3'b0, l5_o[ai]}, {3'b0, e_l5[ai]});
        chk(t_in, {3'b0, l5_o[1-ai]}, {3'b0, e_l5[1-ai]});
    endtask

    task automatic access(input int ncyc, input logic per, input logic mb, input logic bs,
                          input logic ea, input logic [2:0] s, input logic [7:0] a0,
                          input int follow_pct);
        for (int c = 0; c < ncyc; c++) begin
            logic [13:0] w;
            w = 14'($urandom);
            if (int'($urandom % 100) < follow_pct) w[13:10] = 4'b1111;
            for (int q = 0; q < 4; q++) begin
                logic [7:0] a;
                a = (c == 0 && q == 0) ? a0 : 8'($urandom);
                step(1'b1, c == 0, per, mb, bs, ea, 2'(q), w, a, s);
            end
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        e_aq = '0;
        all_high_expect();
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk("R1", line_o[4:1], 4'hF);
        chk("R1", {3'b0, line_o[0]}, 4'h1);
        chk("R1", {2'b0, l5_o}, 4'h3);
        rst = 1'b0;
        @(negedge clk);

        // R5: directed line-0 codes; R7 lone follow code holds
        access(1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, {2'b01, 2'b00, 10'h0}, 8'h00, 3'd0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, {2'b01, 2'b00, 10'h0}, 8'h00, 3'd0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, {2'b10, 2'b11, 10'h0}, 8'h00, 3'd0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, {2'b11, 2'b10, 10'h0}, 8'h00, 3'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 14'h0, 8'h00, 3'd0);

        // R6: follow bit 7, then live bus changes; R8 early value on both machines
        access(3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 8'h80, 100);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 14'h0, 8'h00, 3'd0);
        access(2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3, 8'h08, 100);
        access(2, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00, 50);

        // Random mix: R2 R3 R4 R9 R10 R11
        for (int n = 0; n < 400; n++) begin
            access(1 + int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 3'($urandom), 8'($urandom), 30);
            if ($urandom % 3 == 0)
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'($urandom), 14'($urandom),
                     8'($urandom), 3'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule